// File: doc/BRIEF.md
# Exception Entry Vector and Cause Unit

This unit decides where a processor core goes when an exception is taken and which exception-state registers change as it does so. On a single-cycle request it gets four kinds of input. The first is the exception class: general, error (non-maskable interrupt or soft reset) or debug. The second is the cause code. The third is a flag that marks a TLB miss with no matching entry. The fourth is the core's current state: the PC, whether the faulting instruction sits in a branch delay slot, the exception-base register and the status bits EXL, BEV and IV.

One clock edge later the unit delivers the redirect target and a set of write strobes with their data. The general class writes the return address, the branch-delay flag and the cause code, and sets EXL. The error class writes the error return address and sets ERL and BEV. The debug class writes the debug return address and enters debug mode. The register file that holds these values sits outside the unit and applies the strobes.

The vector offset depends on several things:
- the cause code;
- the no-match flag;
- whether EXL was already set;
- IV.

The vector base comes either from the fixed boot region or from the exception-base register, as selected by BEV.

Top module: `exc_entry`

## Requirements
- R1: After reset every strobe output (`redirect_o`, `epc_we_o`, `cause_we_o`, `exl_set_o`, `errorepc_we_o`, `erl_set_o`, `bev_set_o`, `depc_we_o`, `debug_enter_o`) is low and `redirect_pc_o` is zero.
- R2: The request is a single-cycle pulse. The outputs for that request appear on the first clock edge after the pulse and stay there for exactly one cycle. With no request, no strobe is raised.
- R3: A general-class request (`exc_class_i` = 0) raises `cause_we_o`, and `cause_code_o` equals the 5-bit `exc_code_i`. Interrupt is code 0, TLB load is code 2, TLB store is code 3, and other codes pass through unchanged.
- R4: A general-class request uses offset 0x180 unless R5 or R6 applies. The base is `BOOT_BASE`+0x200 when `bev_i` is 1. Otherwise the base is `ebase_i` with bits 9:0 cleared.
- R5: Cause code 0 with `iv_i` = 1 uses offset 0x200.
- R6: Cause code 2 or 3 with `tlb_nomatch_i` = 1 uses offset 0x000 only while `exl_i` is 0. With `exl_i` = 1 it uses offset 0x180.
- R7: A general-class request with `exl_i` = 0 raises `epc_we_o` and `exl_set_o`. `epc_o` is the PC and `bd_o` is 0. If `delay_slot_i` = 1, `epc_o` is instead the PC minus 4 and `bd_o` is 1.
- R8: A general-class request with `exl_i` = 1 raises neither `epc_we_o` nor `exl_set_o`, but still redirects and writes the cause code.
- R9: An error-class request (`exc_class_i` = 1) raises `errorepc_we_o`, `erl_set_o` and `bev_set_o`, with `errorepc_o` following the delay-slot rule of R7. It redirects to `BOOT_BASE` and does not write the cause code.
- R10: A debug-class request (`exc_class_i` = 2) raises `depc_we_o` and `debug_enter_o`, with `depc_o` following the delay-slot rule of R7. It redirects to `BOOT_BASE`+0x480.
- R11: A request with `exc_class_i` = 3 is ignored and raises no strobe.
- R12: Each request raises at most one of `epc_we_o`, `errorepc_we_o` and `depc_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Single-cycle exception request |
| exc_class_i | input | 2 | 0 general, 1 error, 2 debug, 3 none |
| exc_code_i | input | 5 | Cause code for the general class |
| tlb_nomatch_i | input | 1 | TLB miss had no matching entry |
| pc_i | input | ADDR_W | PC of the faulting instruction |
| delay_slot_i | input | 1 | Faulting instruction is in a branch delay slot |
| ebase_i | input | ADDR_W | Exception-base register |
| exl_i | input | 1 | Current EXL status bit |
| bev_i | input | 1 | Current BEV status bit |
| iv_i | input | 1 | Dedicated interrupt vector enable |
| redirect_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | ADDR_W | Redirect target |
| epc_we_o | output | 1 | Return-address write strobe |
| epc_o | output | ADDR_W | Return address |
| bd_o | output | 1 | Branch-delay flag written with the return address |
| cause_we_o | output | 1 | Cause code write strobe |
| cause_code_o | output | 5 | Cause code |
| exl_set_o | output | 1 | Set EXL |
| errorepc_we_o | output | 1 | Error return-address write strobe |
| errorepc_o | output | ADDR_W | Error return address |
| erl_set_o | output | 1 | Set ERL |
| bev_set_o | output | 1 | Set BEV |
| depc_we_o | output | 1 | Debug return-address write strobe |
| depc_o | output | ADDR_W | Debug return address |
| debug_enter_o | output | 1 | Enter debug mode |

## Verification
The bench uses the defaults: `ADDR_W` = 32 and `BOOT_BASE` = 0xBFC00000. This makes the fixed boot, boot-vector and debug targets directly comparable with a 32-bit exception base.

The exception base is chosen with nonzero low bits, so the bench can observe the masking of bits 9:0. Toggling EXL, BEV, IV, the no-match flag and the delay-slot flag reaches every combination of offset selection for the interrupt and TLB codes. It also reaches the PC-minus-4 return path.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    EXC_GENERAL = 2'd0,
    EXC_ERROR   = 2'd1,
    EXC_DEBUG   = 2'd2,
    EXC_NONE    = 2'd3
  } exc_class_e;

  localparam int unsigned CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;

  localparam logic [11:0] OFF_GENERAL = 12'h180;
  localparam logic [11:0] OFF_INTVEC  = 12'h200;
  localparam logic [11:0] OFF_REFILL  = 12'h000;
  localparam logic [11:0] OFF_BEVBASE = 12'h200;
  localparam logic [11:0] OFF_DEBUG   = 12'h480;
endpackage

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              delay_slot_i,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              bd_o
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  // Restart at the branch when the fault sits in its delay slot
  always_comb begin
    ret_addr_o = delay_slot_i ? (pc_i - INSN_BYTES) : pc_i;
    bd_o       = delay_slot_i;
  end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
#(
  parameter int unsigned  ADDR_W    = 32,
  parameter logic [31:0]  BOOT_BASE = 32'hBFC0_0000
) (
  input  exc_class_e        class_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tlb_nomatch_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic [ADDR_W-1:0] ebase_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned      EBASE_LSB = 10;
  localparam logic [ADDR_W-1:0] BOOT_A   = ADDR_W'(BOOT_BASE);
  localparam logic [ADDR_W-1:0] EB_MASK  = ~((ADDR_W'(1) << EBASE_LSB) - ADDR_W'(1));

  logic [11:0]       gen_off;
  logic [ADDR_W-1:0] gen_base;
  logic              is_tlb;

  always_comb begin
    is_tlb = (code_i == CODE_TLBL) || (code_i == CODE_TLBS);
    if (code_i == CODE_INT && iv_i)               gen_off = OFF_INTVEC;
    else if (is_tlb && tlb_nomatch_i && !exl_i)   gen_off = OFF_REFILL;
    else                                          gen_off = OFF_GENERAL;
    gen_base = bev_i ? (BOOT_A + ADDR_W'(OFF_BEVBASE)) : (ebase_i & EB_MASK);

    unique case (class_i)
      EXC_ERROR: target_o = BOOT_A;
      EXC_DEBUG: target_o = BOOT_A + ADDR_W'(OFF_DEBUG);
      default:   target_o = gen_base + ADDR_W'(gen_off);
    endcase
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_class_i,
  input  logic [4:0]        exc_code_i,
  input  logic              tlb_nomatch_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              delay_slot_i,
  input  logic [ADDR_W-1:0] ebase_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic              epc_we_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic              bd_o,
  output logic              cause_we_o,
  output logic [4:0]        cause_code_o,
  output logic              exl_set_o,
  output logic              errorepc_we_o,
  output logic [ADDR_W-1:0] errorepc_o,
  output logic              erl_set_o,
  output logic              bev_set_o,
  output logic              depc_we_o,
  output logic [ADDR_W-1:0] depc_o,
  output logic              debug_enter_o
);
  exc_class_e        cls;
  logic [ADDR_W-1:0] target, ret_addr;
  logic              ret_bd;
  logic              take, is_gen, is_err, is_dbg;

  assign cls = exc_class_e'(exc_class_i);

  exc_vec_sel #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_vec (
    .class_i      (cls),
    .code_i       (exc_code_i),
    .tlb_nomatch_i(tlb_nomatch_i),
    .exl_i        (exl_i),
    .bev_i        (bev_i),
    .iv_i         (iv_i),
    .ebase_i      (ebase_i),
    .target_o     (target)
  );

  exc_ret_addr #(.ADDR_W(ADDR_W)) u_ret (
    .pc_i        (pc_i),
    .delay_slot_i(delay_slot_i),
    .ret_addr_o  (ret_addr),
    .bd_o        (ret_bd)
  );

  always_comb begin
    take   = exc_req_i && (cls != EXC_NONE);
    is_gen = take && (cls == EXC_GENERAL);
    is_err = take && (cls == EXC_ERROR);
    is_dbg = take && (cls == EXC_DEBUG);
  end

  // Strobes: one-cycle pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      epc_we_o      <= 1'b0;
      cause_we_o    <= 1'b0;
      exl_set_o     <= 1'b0;
      errorepc_we_o <= 1'b0;
      erl_set_o     <= 1'b0;
      bev_set_o     <= 1'b0;
      depc_we_o     <= 1'b0;
      debug_enter_o <= 1'b0;
    end else begin
      redirect_o    <= take;
      epc_we_o      <= is_gen && !exl_i;
      exl_set_o     <= is_gen && !exl_i;
      cause_we_o    <= is_gen;
      errorepc_we_o <= is_err;
      erl_set_o     <= is_err;
      bev_set_o     <= is_err;
      depc_we_o     <= is_dbg;
      debug_enter_o <= is_dbg;
    end
  end

  // Data: captured only when the matching strobe fires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_pc_o <= '0;
      epc_o         <= '0;
      bd_o          <= 1'b0;
      cause_code_o  <= '0;
      errorepc_o    <= '0;
      depc_o        <= '0;
    end else begin
      if (take) redirect_pc_o <= target;
      if (is_gen && !exl_i) begin
        epc_o <= ret_addr;
        bd_o  <= ret_bd;
      end
      if (is_gen) cause_code_o <= exc_code_i;
      if (is_err) errorepc_o   <= ret_addr;
      if (is_dbg) depc_o       <= ret_addr;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exc_req_i,
  input logic [1:0]        exc_class_i,
  input logic              exl_i,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] redirect_pc_o,
  input logic              epc_we_o,
  input logic              exl_set_o,
  input logic              cause_we_o,
  input logic              errorepc_we_o,
  input logic              depc_we_o
);
  assert_redirect_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_class_i != 2'd3 |=> redirect_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_i |=> !redirect_o && !cause_we_o && !epc_we_o);

  assert_epc_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_class_i == 2'd0 && !exl_i |=> epc_we_o && exl_set_o);

  assert_exl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_class_i == 2'd0 && exl_i |=> !epc_we_o && !exl_set_o && cause_we_o);

  assert_error_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_class_i == 2'd1 |=> redirect_pc_o == ADDR_W'(BOOT_BASE) && !cause_we_o);

  assert_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_class_i == 2'd3 |=> !redirect_o);

  assert_one_save_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({epc_we_o, errorepc_we_o, depc_we_o}));
endmodule

bind exc_entry exc_entry_chk #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .exc_req_i    (exc_req_i),
  .exc_class_i  (exc_class_i),
  .exl_i        (exl_i),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o),
  .epc_we_o     (epc_we_o),
  .exl_set_o    (exl_set_o),
  .cause_we_o   (cause_we_o),
  .errorepc_we_o(errorepc_we_o),
  .depc_we_o    (depc_we_o)
);

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
  localparam int unsigned AW = 32;
  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, nomatch = 1'b0, ds = 1'b0, exl = 1'b0, bev = 1'b0, iv = 1'b0;
  logic [1:0] cls = 2'd0;
  logic [4:0] code = 5'd0;
  logic [AW-1:0] pc = '0, ebase = 32'h8000_1234;

  logic redirect, epc_we, bd, cause_we, exl_set, eepc_we, erl_set, bev_set, depc_we, dbg_en;
  logic [AW-1:0] rpc, epc, eepc, depc;
  logic [4:0] ccode;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry #(.ADDR_W(AW), .BOOT_BASE(BOOT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .exc_class_i(cls), .exc_code_i(code),
    .tlb_nomatch_i(nomatch), .pc_i(pc), .delay_slot_i(ds), .ebase_i(ebase),
    .exl_i(exl), .bev_i(bev), .iv_i(iv),
    .redirect_o(redirect), .redirect_pc_o(rpc), .epc_we_o(epc_we), .epc_o(epc), .bd_o(bd),
    .cause_we_o(cause_we), .cause_code_o(ccode), .exl_set_o(exl_set),
    .errorepc_we_o(eepc_we), .errorepc_o(eepc), .erl_set_o(erl_set), .bev_set_o(bev_set),
    .depc_we_o(depc_we), .depc_o(depc), .debug_enter_o(dbg_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Pulse one request; returns at the negedge after the capturing posedge
  task automatic fire(input logic [1:0] c, input logic [4:0] k, input logic nm,
                      input logic e, input logic b, input logic v,
                      input logic [31:0] p, input logic d);
    @(negedge clk);
    cls = c; code = k; nomatch = nm; exl = e; bev = b; iv = v; pc = p; ds = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [3:0] saves();
    return {1'b0, epc_we, eepc_we, depc_we};
  endfunction

  task automatic t_reset();
    chk("R1 redirect", {31'd0, redirect}, 32'd0);
    chk("R1 strobes", {23'd0, epc_we, cause_we, exl_set, eepc_we, erl_set, bev_set, depc_we, dbg_en, bd}, 32'd0);
    chk("R1 redirect_pc", rpc, 32'd0);
  endtask

  task automatic t_general_plain();
    fire(2'd0, 5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0040_0100, 1'b0);
    chk("R2 redirect", {31'd0, redirect}, 32'd1);
    chk("R3 cause_we", {31'd0, cause_we}, 32'd1);
    chk("R3 code", {27'd0, ccode}, 32'd10);
    chk("R4 ebase target", rpc, 32'h8000_1180);
    chk("R7 epc", epc, 32'h0040_0100);
    chk("R7 bd", {31'd0, bd}, 32'd0);
    chk("R7 we+exl", {30'd0, epc_we, exl_set}, 32'd3);
    chk("R12 one save", {28'd0, saves()}, 32'h4);
    @(negedge clk);
    chk("R2 one-cycle pulse", {29'd0, redirect, cause_we, epc_we}, 32'd0);
  endtask

  task automatic t_bev();
    fire(2'd0, 5'd8, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_2000, 1'b0);
    chk("R4 bev target", rpc, 32'hBFC0_0380);
  endtask

  task automatic t_intvec();
    fire(2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1000, 1'b0);
    chk("R5 iv target", rpc, 32'h8000_1200);
    fire(2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1000, 1'b0);
    chk("R5 no iv", rpc, 32'hBFC0_0380);
  endtask

  task automatic t_refill();
    fire(2'd0, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h3000, 1'b0);
    chk("R6 load refill", rpc, 32'h8000_1000);
    fire(2'd0, 5'd3, 1'b1, 1'b0, 1'b1, 1'b0, 32'h3000, 1'b0);
    chk("R6 store refill bev", rpc, 32'hBFC0_0200);
    fire(2'd0, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3000, 1'b0);
    chk("R6 invalid not refill", rpc, 32'h8000_1180);
    fire(2'd0, 5'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h3000, 1'b0);
    chk("R6 refill with exl", rpc, 32'h8000_1180);
  endtask

  task automatic t_delay_slot();
    fire(2'd0, 5'd13, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0040_0204, 1'b1);
    chk("R7 ds epc", epc, 32'h0040_0200);
    chk("R7 ds bd", {31'd0, bd}, 32'd1);
  endtask

  task automatic t_exl_set();
    fire(2'd0, 5'd12, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0050_0000, 1'b1);
    chk("R8 no epc_we", {30'd0, epc_we, exl_set}, 32'd0);
    chk("R8 epc held", epc, 32'h0040_0200);
    chk("R8 bd held", {31'd0, bd}, 32'd1);
    chk("R8 cause", {26'd0, cause_we, ccode}, 32'h2C);
    chk("R8 redirect", {31'd0, redirect}, 32'd1);
  endtask

  task automatic t_error();
    fire(2'd1, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0060_0008, 1'b1);
    chk("R9 target", rpc, 32'hBFC0_0000);
    chk("R9 errorepc", eepc, 32'h0060_0004);
    chk("R9 strobes", {28'd0, eepc_we, erl_set, bev_set, cause_we}, 32'hE);
    chk("R12 one save", {28'd0, saves()}, 32'h2);
  endtask

  task automatic t_debug();
    fire(2'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0070_0010, 1'b0);
    chk("R10 target", rpc, 32'hBFC0_0480);
    chk("R10 depc", depc, 32'h0070_0010);
    chk("R10 strobes", {29'd0, depc_we, dbg_en, cause_we}, 32'h6);
    fire(2'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0070_0010, 1'b1);
    chk("R10 ds depc", depc, 32'h0070_000C);
  endtask

  task automatic t_ignored();
    fire(2'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0999_0000, 1'b0);
    chk("R11 no strobes", {22'd0, redirect, epc_we, cause_we, exl_set, eepc_we, erl_set, bev_set, depc_we, dbg_en, 1'b0}, 32'd0);
    chk("R11 pc held", rpc, 32'hBFC0_0480);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_general_plain();
    t_bev();
    t_intvec();
    t_refill();
    t_delay_slot();
    t_exl_set();
    t_error();
    t_debug();
    t_ignored();
    repeat (2) @(negedge clk);
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 10000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 10000", cycles);
      finish_run();
    end
  end
endmodule